// File: doc/BRIEF.md
# IR Remote-Control Peripheral Host Register Block

This block sits between a host bus and the codec engines of an infrared remote-control peripheral. It decodes four word locations: carrier divider, control, status and a data port. It keeps the operating mode and the interrupt enable. It tracks the receive flags and drives an active-high interrupt line. It also steers data-port traffic to internal registers that depend on the mode.

The codec engines are outside the block. Each received word arrives on one port with a one-cycle valid strobe and a repeat indication. The block stores the word in the receive register of the current mode. It then locks further words out until the host acknowledges, which it does by writing a 1 to the acknowledge bit of the control register. Transmit words leave through a register with a one-cycle load pulse. The encoder reports the start of a transmission back with a pulse.

The host bus is a single-cycle strobe with a write enable. Writes take effect at the clock edge. Read data is a combinational function of the address.

Top module: `irc_host_regs`

## Requirements
- R1: After reset: control reads 0, status reads 0 (with rx_line high), all three receive registers read 0, irq is 0, tx_load is 0, tx_word is 0, and the carrier divider reads 0x00FFFFFF.
- R2: Address 0 holds a 24-bit carrier divider, loaded from write data bits 23:0. It reads back zero-extended and is driven on clk_div. Nothing else changes it.
- R3: Control (address 1): bits 7:6 hold the mode (00 raw, 01 NEC, 10 RC5, 11 unused) and bit 0 the interrupt enable. Every other bit reads 0, including the acknowledge bit 1, which never stays set.
- R4: A receive strobe that arrives while the receive interrupt flag is clear, in modes 00, 01 or 10, does three things. It stores rx_word in the register of the current mode, it sets the flag (status bit 0), and it copies rx_rep into the repeat flag (status bit 3). In mode 11 the strobe is ignored.
- R5: A receive strobe that arrives while the interrupt flag is set sets the overrun flag (status bit 2). The word is discarded, and the stored data and the repeat flag stay unchanged.
- R6: A control write with bit 1 set clears the interrupt and overrun flags. A receive strobe in the same cycle is then accepted as fresh data.
- R7: irq equals the receive interrupt flag ANDed with the interrupt enable.
- R8: Status bit 1 reads 1 when rx_line is low (mark) and 0 when it is high. Status bits 31:5 read 0.
- R9: In mode 00 or 01, a data-port write loads tx_word, pulses tx_load for the next cycle and sets transmit busy (status bit 4). A tx_start pulse clears busy, unless a data write arrives in the same cycle.
- R10: In mode 10, status bit 4 reads 0. In mode 10 or 11, data-port writes are ignored: no tx_load, and tx_word and busy are unchanged.
- R11: A data-port read returns the raw, NEC or RC5 receive register for mode 00, 01 or 10, and returns 0 in mode 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Active-high interrupt |
| clk_div | output | 24 | Carrier divider value |
| rx_line | input | 1 | Demodulated receive line, low = mark |
| rx_valid | input | 1 | Received word strobe |
| rx_word | input | 32 | Received word |
| rx_rep | input | 1 | Received word is a repeat |
| tx_word | output | 32 | Transmit word |
| tx_load | output | 1 | One-cycle transmit load pulse |
| tx_start | input | 1 | Encoder has started sending |

## Verification
The bench targets the following corner cases:
- **Word during a pending interrupt.** A design that overwrote the held data would show the new word on the data port. A design that forgot the overrun would leave status bit 2 clear.
- **Acknowledge and a new word in the same cycle.** A design that gave the clear priority would drop the word and leave irq low.
- **Mode switch with busy or data pending.** A design that leaked busy in RC5 mode, or read the wrong slot after the switch, would show it on the status or data read.
- **Write racing tx_start.** A design that let the start pulse win would clear busy while a new word is still pending.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic [1:0] {
    MODE_RAW  = 2'b00,
    MODE_NEC  = 2'b01,
    MODE_RC5  = 2'b10,
    MODE_NONE = 2'b11
  } irc_mode_e;

  localparam logic [1:0] A_DIV  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DATA = 2'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_ACK_BIT = 1;
  localparam int CTRL_MODE_LO = 6;
  localparam int NUM_SLOTS    = 3;
endpackage

// File: rtl/irc_rx_hold.sv
module irc_rx_hold
  import irc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  irc_mode_e     mode,
  input  logic          ack,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_rep,
  output logic [DW-1:0] rd_word,
  output logic          int_flag,
  output logic          ovr_flag,
  output logic          rep_flag
);
  logic [NUM_SLOTS-1:0][DW-1:0] slot_q;
  logic int_q, int_d, ovr_q, ovr_d, rep_q, rep_d;
  logic accept, take;

  assign accept = rx_valid && (mode != MODE_NONE);
  assign take   = accept && (!int_q || ack);

  always_comb begin
    int_d = ack ? accept : (int_q | accept);
    ovr_d = ack ? 1'b0 : (ovr_q | (accept & int_q));
    rep_d = take ? rx_rep : rep_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      ovr_q <= 1'b0;
      rep_q <= 1'b0;
    end else begin
      int_q <= int_d;
      ovr_q <= ovr_d;
      rep_q <= rep_d;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic slot_en;
    assign slot_en = take && (mode == irc_mode_e'(2'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= rx_word;
    end
  end

  always_comb begin
    case (mode)
      MODE_RAW: rd_word = slot_q[0];
      MODE_NEC: rd_word = slot_q[1];
      MODE_RC5: rd_word = slot_q[2];
      default:  rd_word = '0;
    endcase
  end

  assign int_flag = int_q;
  assign ovr_flag = ovr_q;
  assign rep_flag = rep_q;

  p_take_sets_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> int_q);
  p_ovr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(int_q));
  p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q && !ack) |=> ($stable(slot_q) && $stable(rep_q)));
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !accept) |=> (!int_q && !ovr_q));
endmodule

// File: rtl/irc_tx_slot.sv
module irc_tx_slot
  import irc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  irc_mode_e     mode,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          tx_start,
  output logic [DW-1:0] tx_word,
  output logic          tx_load,
  output logic          busy_vis
);
  logic [DW-1:0] word_q, word_d;
  logic busy_q, busy_d, load_q, load;

  assign load = wr && (mode == MODE_RAW || mode == MODE_NEC);

  always_comb begin
    word_d = load ? wdata : word_q;
    if (load)          busy_d = 1'b1;
    else if (tx_start) busy_d = 1'b0;
    else               busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      busy_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      word_q <= word_d;
      busy_q <= busy_d;
      load_q <= load;
    end
  end

  assign tx_word  = word_q;
  assign tx_load  = load_q;
  assign busy_vis = busy_q && (mode != MODE_RC5);

  p_load_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> busy_q);
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && tx_start && !load) |=> !busy_q);
  p_rc5_no_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (mode == MODE_RC5 || mode == MODE_NONE)) |=> (!load_q && $stable(word_q)));
endmodule

// File: rtl/irc_host_regs.sv
module irc_host_regs
  import irc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq,
  output logic [DIV_W-1:0] clk_div,
  input  logic             rx_line,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_word,
  input  logic             rx_rep,
  output logic [DW-1:0]    tx_word,
  output logic             tx_load,
  input  logic             tx_start
);
  localparam int STAT_W = 5;

  logic [1:0]       rst_sync;
  logic             rst_i;
  irc_mode_e        mode_q, mode_d;
  logic             en_q, en_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr, wr_div, wr_ctrl, wr_data, ack;
  logic [DW-1:0]    rx_rd;
  logic             rx_int, rx_ovr, rx_rpt, busy_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign wr      = bus_sel && bus_we;
  assign wr_div  = wr && (bus_addr == A_DIV);
  assign wr_ctrl = wr && (bus_addr == A_CTRL);
  assign wr_data = wr && (bus_addr == A_DATA);
  assign ack     = wr_ctrl && bus_wdata[CTRL_ACK_BIT];

  always_comb begin
    div_d  = wr_div ? bus_wdata[DIV_W-1:0] : div_q;
    mode_d = wr_ctrl ? irc_mode_e'(bus_wdata[CTRL_MODE_LO+1:CTRL_MODE_LO]) : mode_q;
    en_d   = wr_ctrl ? bus_wdata[CTRL_EN_BIT] : en_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      div_q  <= '1;
      mode_q <= MODE_RAW;
      en_q   <= 1'b0;
    end else begin
      div_q  <= div_d;
      mode_q <= mode_d;
      en_q   <= en_d;
    end
  end

  irc_rx_hold #(.DW(DW)) i_rx (
    .clk(clk), .rst_n(rst_i), .mode(mode_q), .ack(ack),
    .rx_valid(rx_valid), .rx_word(rx_word), .rx_rep(rx_rep),
    .rd_word(rx_rd), .int_flag(rx_int), .ovr_flag(rx_ovr), .rep_flag(rx_rpt)
  );

  irc_tx_slot #(.DW(DW)) i_tx (
    .clk(clk), .rst_n(rst_i), .mode(mode_q), .wr(wr_data), .wdata(bus_wdata),
    .tx_start(tx_start), .tx_word(tx_word), .tx_load(tx_load), .busy_vis(busy_vis)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      A_CTRL: begin
        bus_rdata[CTRL_MODE_LO+1:CTRL_MODE_LO] = mode_q;
        bus_rdata[CTRL_EN_BIT] = en_q;
      end
      A_STAT: bus_rdata[STAT_W-1:0] = {busy_vis, rx_rpt, rx_ovr, ~rx_line, rx_int};
      default: bus_rdata = rx_rd;
    endcase
  end

  assign irq     = rx_int && en_q;
  assign clk_div = div_q;

  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_i)
    !wr_div |=> $stable(div_q));
  p_ack_drops_irq_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (ack && !rx_valid) |=> !irq);
  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (wr_ctrl && !bus_wdata[CTRL_EN_BIT]) |=> !irq);
endmodule

// File: tb/test_irc_host_regs.sv
module test_irc_host_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  logic [23:0] clk_div;
  logic        rx_line, rx_valid, rx_rep, tx_load, tx_start;
  logic [31:0] rx_word, tx_word;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of the register state
  logic [23:0] m_div;
  logic [1:0]  m_mode;
  logic        m_en, m_int, m_ovr, m_rep, m_busy, m_load;
  logic [31:0] m_slot [3];
  logic [31:0] m_tx;

  always #5 clk = ~clk;

  irc_host_regs i_irc_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .clk_div(clk_div), .rx_line(rx_line), .rx_valid(rx_valid),
    .rx_word(rx_word), .rx_rep(rx_rep), .tx_word(tx_word), .tx_load(tx_load),
    .tx_start(tx_start)
  );

  function automatic logic [31:0] exp_read(input logic [1:0] a, input logic line);
    case (a)
      2'd0: return {8'h0, m_div};
      2'd1: return {24'h0, m_mode, 5'h0, m_en};
      2'd2: return {27'h0, m_busy && (m_mode != 2'b10), m_rep, m_ovr, ~line, m_int};
      default: return (m_mode == 2'b11) ? 32'h0 : m_slot[m_mode];
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_div = 24'hFFFFFF; m_mode = 2'b00; m_en = 0; m_int = 0; m_ovr = 0;
    m_rep = 0; m_busy = 0; m_load = 0; m_tx = 0;
    for (int i = 0; i < 3; i++) m_slot[i] = 0;
  endtask

  // drive one cycle at the falling edge, check outputs, advance the model
  task automatic cyc(input logic sel, input logic we, input logic [1:0] a,
                     input logic [31:0] wd, input logic line, input logic rv,
                     input logic [31:0] rw, input logic rr, input logic ts);
    logic ackw, acc, take, load;
    string tag;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd; rx_line = line;
    rx_valid = rv; rx_word = rw; rx_rep = rr; tx_start = ts;
    #1;
    case (a)
      2'd0: tag = "R2 divider read";
      2'd1: tag = "R3 control read";
      2'd2: tag = "R4 R5 R6 R8 R9 R10 status read";
      default: tag = "R11 R4 R5 data read";
    endcase
    check(tag, bus_rdata, exp_read(a, line));
    check("R7 irq", {31'h0, irq}, {31'h0, m_int & m_en});
    check("R2 clk_div", {8'h0, clk_div}, {8'h0, m_div});
    check("R9 tx_word", tx_word, m_tx);
    check("R9 R10 tx_load", {31'h0, tx_load}, {31'h0, m_load});
    ackw = sel && we && a == 2'd1 && wd[1];
    acc  = rv && m_mode != 2'b11;
    take = acc && (!m_int || ackw);
    if (take) begin m_slot[m_mode] = rw; m_rep = rr; end
    m_ovr = ackw ? 1'b0 : (m_ovr | (acc & m_int));
    m_int = ackw ? acc : (m_int | acc);
    load = sel && we && a == 2'd3 && (m_mode == 2'b00 || m_mode == 2'b01);
    if (load) m_tx = wd;
    m_busy = load ? 1'b1 : (ts ? 1'b0 : m_busy);
    m_load = load;
    if (sel && we && a == 2'd0) m_div = wd[23:0];
    if (sel && we && a == 2'd1) begin m_mode = wd[7:6]; m_en = wd[0]; end
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a);
    cyc(1, 0, a, 32'h0, 1, 0, 32'h0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51C0_0DE5));
    rst_n = 0;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; rx_line = 1;
    rx_valid = 0; rx_word = 0; rx_rep = 0; tx_start = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset values seen while reset is held
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #1;
      check("R1 reset read", bus_rdata, exp_read(2'(a), 1'b1));
      check("R1 reset irq", {31'h0, irq}, 32'h0);
    end
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    rd(0); rd(1); rd(2); rd(3);

    // R2 divider write and readback
    cyc(1, 1, 0, 32'hA5_123456, 1, 0, 0, 0, 0); rd(0);
    // R3 control with all bits set: mode 11, acknowledge not retained
    cyc(1, 1, 1, 32'hFFFF_FFFF, 1, 0, 0, 0, 0); rd(1);
    // R4 mode 11 ignores words; R10 data write ignored in mode 11
    cyc(1, 1, 3, 32'h1111_2222, 0, 1, 32'hDEAD_0001, 1, 0); rd(2); rd(3);
    // NEC mode, interrupts on; R4 accept, R5 overrun, R7 irq
    cyc(1, 1, 1, 32'h0000_0041, 1, 0, 0, 0, 0);
    cyc(0, 0, 3, 0, 0, 1, 32'h00FF_20DF, 1, 0); rd(2); rd(3);
    cyc(0, 0, 3, 0, 1, 1, 32'h1234_5678, 0, 0); rd(2); rd(3);
    // R6 acknowledge with a word in the same cycle
    cyc(1, 1, 1, 32'h0000_0043, 1, 1, 32'hCAFE_F00D, 0, 0); rd(2); rd(3);
    cyc(1, 1, 1, 32'h0000_0043, 1, 0, 0, 0, 0); rd(2);
    // R9 write racing tx_start, then start alone
    cyc(1, 1, 3, 32'hB00B_0001, 1, 0, 0, 0, 0);
    cyc(1, 1, 3, 32'hB00B_0002, 1, 0, 0, 0, 1); rd(2);
    cyc(0, 0, 2, 0, 1, 0, 0, 0, 1); rd(2);
    // R10 busy hidden in RC5 mode; R11 RC5 slot routing
    cyc(1, 1, 3, 32'hB00B_0003, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 32'h0000_0080, 1, 0, 0, 0, 0); rd(2);
    cyc(1, 1, 3, 32'h7777_7777, 1, 1, 32'h0000_3ABC, 0, 0); rd(2); rd(3);
    cyc(1, 1, 1, 32'h0000_0002, 1, 0, 0, 0, 0); rd(2); rd(3);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] wd;
      logic [1:0]  a;
      a  = 2'($urandom_range(0, 3));
      wd = $urandom();
      if (a == 2'd1 && $urandom_range(0, 3) != 0) wd[7:6] = 2'($urandom_range(0, 2));
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, a, wd,
          $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0, $urandom(),
          $urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule